// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block derives a group of differential CPU clock pairs from a fast source clock. It parks selected pairs on an asynchronous, active-low stop request. Each pair is either stoppable or free-running, chosen by one bit of a mask that a register interface supplies. While the request is active, the stoppable pairs sit with the true output high and the complement output low. The free-running pairs and every other clock keep toggling.

The request is qualified by two falling edges of the output clock before it has any effect. Both entry into the parked state and exit from it fall on the normal output edge grid, so the outputs never show a short or a stretched pulse. A per-pair flag reports which pairs are currently parked.

Top module: `clkstop_ctrl`

## Requirements
- R1: A synchronous active-high reset forces every pair to run with `parked` all zero, `clk_t` all low and `clk_c` all high; a reset taken while pairs are parked releases them.
- R2: A running pair toggles with a period of 2*HALF_DIV source cycles, and `clk_c` is always the bitwise inverse of `clk_t`.
- R3: Once `stop_n` has been seen low on two consecutive falling output edges, every pair whose `stop_mask` bit is 1 parks at the next rising output edge. From then on it holds `clk_t`=1 and `clk_c`=0, and its `parked` bit rises in the same cycle as that rising edge.
- R4: Pairs whose `stop_mask` bit is 0 keep toggling at the normal period while other pairs are parked.
- R5: A low pulse on `stop_n` that is seen on only one falling output edge parks no pair.
- R6: After `stop_n` returns high, a parked pair stays parked through the first falling output edge. It resumes with a falling edge of `clk_t` at the second falling output edge, and `parked` drops in that same cycle.
- R7: Every low phase of `clk_t` lasts exactly HALF_DIV source cycles, and every high phase lasts a non-zero multiple of HALF_DIV. Resumed pairs are phase-aligned with the free-running pairs.
- R8: A `stop_mask` bit is acted on only at output edges. Setting a bit while the stop is active parks that pair at the next rising edge. Clearing the bit of a parked pair releases it at the next falling edge. In between, the change has no effect on `parked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_n | input | 1 | Asynchronous stop request, active low |
| stop_mask | input | N_PAIRS | 1 marks a pair as stoppable |
| clk_t | output | N_PAIRS | True clock level per pair |
| clk_c | output | N_PAIRS | Complement clock level per pair |
| parked | output | N_PAIRS | 1 while the pair is held in the stopped state |

## Verification
The checker watches the edge grid on every cycle. It checks the low phases for exact length and the high phases for whole multiples of HALF_DIV. It checks that a parked pair shows true high and complement low, and that `parked` only rises on a rising `clk_t` edge and only falls on a falling one. It also checks that a pair parks only with its mask bit set. The two-edge qualification, the release latency counted in falling edges, the rejection of a one-edge pulse and the timing of mask edits depend on where the request lands against the output clock. Only the directed scenarios, which place each request just after a known edge, can show those.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
   // one-cycle markers for the output phase edges, valid in the source cycle
   // whose closing edge moves the output phase
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;
endpackage

// File: rtl/clkstop_phase.sv
`timescale 1ns/1ps
module clkstop_phase #(
   parameter int HALF_DIV = 4
) (
   input  logic                    clk_src,
   input  logic                    rst,
   output logic                    ph,
   output clkstop_pkg::edge_ev_t   ev
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic tick;

   generate
      if (HALF_DIV == 1) begin : g_div1
         assign tick = 1'b1;
      end else begin : g_divn
         logic [CW-1:0] cnt;
         always_ff @(posedge clk_src) begin
            if (rst)                           cnt <= '0;
            else if (cnt == CW'(HALF_DIV - 1)) cnt <= '0;
            else                               cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk_src) begin
      if (rst) ph <= 1'b0;
      else     ph <= ph ^ tick;
   end

   assign ev.rise = tick & ~ph;
   assign ev.fall = tick &  ph;
endmodule

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync (
   input  logic                  clk_src,
   input  logic                  rst,
   input  clkstop_pkg::edge_ev_t ev,
   input  logic                  stop_n,
   output logic                  req,
   output logic                  run_seen
);
   logic s1, s2;

   // both stages advance only on falling output edges
   always_ff @(posedge clk_src) begin
      if (rst) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else if (ev.fall) begin
         s1 <= stop_n;
         s2 <= s1;
      end
   end

   // stop only when the request was low on two falling edges in a row
   assign req      = ~s1 & ~s2;
   // latest falling-edge sample saw the request released
   assign run_seen = s1;
endmodule

// File: rtl/clkstop_pair.sv
`timescale 1ns/1ps
module clkstop_pair (
   input  logic                  clk_src,
   input  logic                  rst,
   input  clkstop_pkg::edge_ev_t ev,
   input  logic                  ph,
   input  logic                  req,
   input  logic                  run_seen,
   input  logic                  stoppable,
   output logic                  t_o,
   output logic                  c_o,
   output logic                  parked_o
);
   // enter on a rising edge (true already going high), leave on a falling edge
   always_ff @(posedge clk_src) begin
      if (rst)
         parked_o <= 1'b0;
      else if (ev.rise && req && stoppable)
         parked_o <= 1'b1;
      else if (ev.fall && (run_seen || !stoppable))
         parked_o <= 1'b0;
   end

   assign t_o = ph | parked_o;
   assign c_o = ~t_o;
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
   parameter int N_PAIRS  = 4,
   parameter int HALF_DIV = 4
) (
   input  logic               clk_src,
   input  logic               rst,
   input  logic               stop_n,
   input  logic [N_PAIRS-1:0] stop_mask,
   output logic [N_PAIRS-1:0] clk_t,
   output logic [N_PAIRS-1:0] clk_c,
   output logic [N_PAIRS-1:0] parked
);
   generate
      if (N_PAIRS < 1) begin : g_bad_pairs
         $error("clkstop_ctrl: N_PAIRS must be at least 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("clkstop_ctrl: HALF_DIV must be at least 1");
      end
   endgenerate

   logic                  ph;
   clkstop_pkg::edge_ev_t ev;
   logic                  req;
   logic                  run_seen;

   clkstop_phase #(.HALF_DIV(HALF_DIV)) u_phase (
      .clk_src (clk_src),
      .rst     (rst),
      .ph      (ph),
      .ev      (ev)
   );

   clkstop_sync u_sync (
      .clk_src  (clk_src),
      .rst      (rst),
      .ev       (ev),
      .stop_n   (stop_n),
      .req      (req),
      .run_seen (run_seen)
   );

   generate
      for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
         clkstop_pair u_pair (
            .clk_src   (clk_src),
            .rst       (rst),
            .ev        (ev),
            .ph        (ph),
            .req       (req),
            .run_seen  (run_seen),
            .stoppable (stop_mask[i]),
            .t_o       (clk_t[i]),
            .c_o       (clk_c[i]),
            .parked_o  (parked[i])
         );
      end
   endgenerate
endmodule

// File: rtl/clkstop_chk.sv
`timescale 1ns/1ps
module clkstop_chk #(
   parameter int N_PAIRS  = 4,
   parameter int HALF_DIV = 4
) (
   input logic               clk_src,
   input logic               rst,
   input logic               stop_n,
   input logic [N_PAIRS-1:0] stop_mask,
   input logic [N_PAIRS-1:0] clk_t,
   input logic [N_PAIRS-1:0] clk_c,
   input logic [N_PAIRS-1:0] parked
);
   a_r1_reset_clears: assert property (@(posedge clk_src)
      $past(rst) |-> (parked == '0) && (clk_t == '0));

   generate
      for (genvar i = 0; i < N_PAIRS; i++) begin : g_chk
         logic [19:0] lo_len;
         logic [19:0] hi_len;

         always_ff @(posedge clk_src) begin
            if (rst) begin
               lo_len <= '0;
               hi_len <= '0;
            end else begin
               lo_len <= clk_t[i] ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1'b1);
               hi_len <= clk_t[i] ? ((hi_len == '1) ? hi_len : hi_len + 1'b1) : '0;
            end
         end

         a_r7_low_phase: assert property (@(posedge clk_src) disable iff (rst)
            $rose(clk_t[i]) |-> (lo_len == 20'(HALF_DIV)));

         a_r7_high_phase: assert property (@(posedge clk_src) disable iff (rst)
            $fell(clk_t[i]) |-> (hi_len != '0) && ((hi_len % 20'(HALF_DIV)) == '0));

         a_r3_parked_level: assert property (@(posedge clk_src) disable iff (rst)
            parked[i] |-> (clk_t[i] && !clk_c[i]));

         a_r3_park_on_rise: assert property (@(posedge clk_src) disable iff (rst)
            $rose(parked[i]) |-> $rose(clk_t[i]));

         a_r6_release_on_fall: assert property (@(posedge clk_src) disable iff (rst)
            $fell(parked[i]) |-> $fell(clk_t[i]));

         a_r8_park_needs_mask: assert property (@(posedge clk_src) disable iff (rst)
            $rose(parked[i]) |-> $past(stop_mask[i]));
      end
   endgenerate
endmodule

bind clkstop_ctrl clkstop_chk #(.N_PAIRS(N_PAIRS), .HALF_DIV(HALF_DIV)) u_chk (.*);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
   localparam int NP = 4;
   localparam int HD = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          stop_n;
   logic [NP-1:0] stop_mask;
   logic [NP-1:0] clk_t, clk_c, parked;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   clkstop_ctrl #(.N_PAIRS(NP), .HALF_DIV(HD)) u0 (
      .clk_src   (clk),
      .rst       (rst),
      .stop_n    (stop_n),
      .stop_mask (stop_mask),
      .clk_t     (clk_t),
      .clk_c     (clk_c),
      .parked    (parked)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // wait until pair 0 (never stoppable) shows the requested edge
   task automatic wait_edge(input bit rising);
      logic prev;
      int   n = 0;
      prev = clk_t[0];
      forever begin
         @(negedge clk);
         n++;
         if (clk_t[0] == rising && prev != rising) break;
         prev = clk_t[0];
         if (n > 64) begin
            chk(1'b0, "WD", "edge timeout", 32'(n), 32'd64);
            break;
         end
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; stop_n = 1'b1; stop_mask = '0;
      repeat (3) step();
      rst = 1'b0;
      chk(parked == '0, "R1", "parked after reset", 32'(parked), 32'h0);
      chk(clk_t == '0, "R1", "clk_t after reset", 32'(clk_t), 32'h0);
      chk(clk_c == '1, "R1", "clk_c after reset", 32'(clk_c), 32'hf);
   endtask

   task automatic t_period();
      int  n = 0;
      bit  inv_ok = 1'b1;
      wait_edge(1'b1);
      forever begin
         logic prev;
         prev = clk_t[0];
         step();
         n++;
         if (clk_c != ~clk_t) inv_ok = 1'b0;
         if (clk_t[0] && !prev) break;
         if (n > 64) break;
      end
      chk(n == 2 * HD, "R2", "period in source cycles", 32'(n), 32'(2 * HD));
      chk(inv_ok, "R2", "complement is inverse", 32'(inv_ok), 32'd1);
   endtask

   task automatic t_stop();
      int   falls0 = 0, falls2 = 0;
      bit   held = 1'b1;
      logic p0, p2;
      stop_mask = 4'b1010;
      wait_edge(1'b0);
      stop_n = 1'b0;
      wait_edge(1'b0);
      chk(parked == '0, "R5", "no park after one falling edge", 32'(parked), 32'h0);
      wait_edge(1'b0);
      chk(parked == '0, "R3", "no park before rising edge", 32'(parked), 32'h0);
      chk(clk_t[1] == 1'b0, "R3", "pair1 still low phase", 32'(clk_t[1]), 32'h0);
      wait_edge(1'b1);
      chk(parked == 4'b1010, "R3", "parked flags", 32'(parked), 32'ha);
      chk((clk_t & 4'b1010) == 4'b1010, "R3", "parked true high", 32'(clk_t), 32'ha);
      chk((clk_c & 4'b1010) == 4'b0000, "R3", "parked complement low", 32'(clk_c), 32'h0);
      p0 = clk_t[0]; p2 = clk_t[2];
      repeat (6 * HD) begin
         step();
         if (p0 && !clk_t[0]) falls0++;
         if (p2 && !clk_t[2]) falls2++;
         p0 = clk_t[0]; p2 = clk_t[2];
         if (!clk_t[1] || !clk_t[3]) held = 1'b0;
      end
      chk(held, "R3", "parked pairs stay high", 32'(held), 32'd1);
      chk(falls0 == 3, "R4", "pair0 keeps toggling", 32'(falls0), 32'd3);
      chk(falls2 == 3, "R4", "pair2 keeps toggling", 32'(falls2), 32'd3);
   endtask

   task automatic t_release();
      bit aligned = 1'b1;
      wait_edge(1'b0);
      stop_n = 1'b1;
      wait_edge(1'b0);
      chk(parked == 4'b1010, "R6", "still parked after first fall", 32'(parked), 32'ha);
      chk(clk_t[1] == 1'b1, "R6", "pair1 high after first fall", 32'(clk_t[1]), 32'h1);
      wait_edge(1'b0);
      chk(parked == '0, "R6", "released at second fall", 32'(parked), 32'h0);
      chk(clk_t == '0, "R6", "all true low at release", 32'(clk_t), 32'h0);
      repeat (4 * HD) begin
         step();
         if (clk_t != {NP{clk_t[0]}}) aligned = 1'b0;
      end
      chk(aligned, "R7", "resumed pairs aligned", 32'(aligned), 32'd1);
   endtask

   task automatic t_pulse();
      bit quiet = 1'b1;
      stop_mask = 4'b1010;
      wait_edge(1'b0);
      stop_n = 1'b0;
      wait_edge(1'b0);
      stop_n = 1'b1;
      repeat (8 * HD) begin
         step();
         if (parked != '0 || clk_t[1] != clk_t[0]) quiet = 1'b0;
      end
      chk(quiet, "R5", "one-edge pulse ignored", 32'(parked), 32'h0);
   endtask

   task automatic t_mask();
      stop_mask = 4'b1010;
      stop_n = 1'b0;
      wait_edge(1'b0);
      wait_edge(1'b0);
      wait_edge(1'b1);
      chk(parked == 4'b1010, "R8", "parked before mask edit", 32'(parked), 32'ha);
      stop_mask = 4'b1000;
      step();
      chk(parked == 4'b1010, "R8", "mask clear waits for fall", 32'(parked), 32'ha);
      wait_edge(1'b0);
      chk(parked == 4'b1000, "R8", "mask clear released pair1", 32'(parked), 32'h8);
      chk(clk_t[1] == 1'b0 && clk_t[3] == 1'b1, "R8", "pair levels after clear",
          32'(clk_t), 32'h8);
      stop_mask = 4'b1100;
      step();
      chk(parked == 4'b1000, "R8", "mask set waits for rise", 32'(parked), 32'h8);
      wait_edge(1'b1);
      chk(parked == 4'b1100, "R8", "mask set parked pair2", 32'(parked), 32'hc);
      chk(clk_t[2] == 1'b1, "R8", "pair2 true high", 32'(clk_t[2]), 32'h1);
   endtask

   task automatic t_reset_parked();
      bit quiet = 1'b1;
      rst = 1'b1;
      repeat (3) step();
      chk(parked == '0, "R1", "reset clears parked", 32'(parked), 32'h0);
      chk(clk_t == '0, "R1", "reset forces true low", 32'(clk_t), 32'h0);
      stop_n = 1'b1;
      rst = 1'b0;
      repeat (4 * HD) begin
         step();
         if (parked != '0) quiet = 1'b0;
      end
      chk(quiet, "R1", "running after reset", 32'(parked), 32'h0);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL WD watchdog expired actual=%0d expected=%0d", 100000, 0);
      finish_up();
   end

   initial begin
      t_reset();
      t_period();
      t_stop();
      t_release();
      t_pulse();
      t_mask();
      t_reset_parked();
      finish_up();
   end
endmodule